// File: doc/BRIEF.md
# Double-Edge PWM Generator with Released Shadow Matches

The block is a pulse-width modulator built around a free-running timer with a programmable prescaler. A bank of match registers sets the period and the edge positions of several output channels. Each channel is either single-edge or double-edge. A single-edge channel is high from the start of the period until its clear match. A double-edge channel has a set match and a clear match of its own. This lets several outputs be placed so they never overlap, each with its own width and phase.

Software writes new match values into shadow copies. A shadow value reaches the active register only once software marks it released, and then only when the period ends. All edges of one period therefore come from one consistent set of values. With the PWM mode switched off, the counter runs as a plain timer: it wraps only at its full width, the outputs stay low, and match writes take effect immediately.

Top module: `dual_edge_pwm`

## Requirements
- R1: While the run bit (CTRL bit 0) is set, the counter `tc_value` advances once every PRESCALE+1 clock cycles. While the run bit is clear, the counter holds its value.
- R2: With PWM mode on (CTRL bit 1), the counter counts from 0 up to active match 0 and then returns to 0, so one period lasts match0+1 counter steps.
- R3: In PWM mode, a write to a match register (address k, for k = 0 to 2*NCH) changes only its shadow copy. Output behaviour and the counter are unaffected until that value is released.
- R4: Writing a 1 to bit k of the release register (address 2*NCH+3) sets `latch_pend[k]`. At the counter step that ends a period, each pending shadow value is copied to its active register and its pending bit clears itself.
- R5: A single-edge channel c (CTRL bit 2+c = 0) is high while the counter is below active match 2c+2 and low from there to the end of the period.
- R6: A double-edge channel c (CTRL bit 2+c = 1) is high while the counter is at or above active match 2c+1 and below active match 2c+2.
- R7: A double-edge channel whose set and clear matches are equal stays low for the whole period.
- R8: With PWM mode off, the counter passes match 0 and wraps only at 2^TW, all outputs are low, and match writes update the active register at once. `match_hit[k]` is high while the run bit is set and the counter equals active match k.
- R9: After reset the counter, all match registers, all pending bits and all outputs are 0. CTRL is at address 2*NCH+1 and PRESCALE at address 2*NCH+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | $clog2(2*NCH+4) | Register address |
| wr_data | input | TW | Register write data |
| pwm_out | output | NCH | Channel outputs |
| tc_value | output | TW | Current counter value |
| match_hit | output | 2*NCH+1 | Counter equals active match k |
| latch_pend | output | 2*NCH+1 | Released values awaiting the period boundary |

## Verification
The hardest case to reach is a release issued partway through a period, while the old values still control the rest of that period. The stimulus polls the counter to a known early step. It then writes a new clear position and a release during that period. The expected outputs are queued as the old waveform for the remaining steps, followed by the new waveform for the next period, so a transfer that comes too early shows up as a mismatch on a specific counter value.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
   typedef enum logic {
      EDGE_SINGLE = 1'b0,
      EDGE_DOUBLE = 1'b1
   } edge_mode_e;

   localparam int CTRL_RUN_BIT = 0;
   localparam int CTRL_PWM_BIT = 1;
   localparam int CTRL_DBL_LSB = 2;

   function automatic int ctrl_addr(input int nmatch);
      return nmatch;
   endfunction

   function automatic int psc_addr(input int nmatch);
      return nmatch + 1;
   endfunction

   function automatic int rel_addr(input int nmatch);
      return nmatch + 2;
   endfunction
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
   parameter int TW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [TW-1:0] limit,
   output logic          tick
);
   logic [TW-1:0] pc_q;

   assign tick = run && (pc_q >= limit);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q <= '0;
      end else if (run) begin
         if (pc_q >= limit) pc_q <= '0;
         else               pc_q <= pc_q + 1'b1;
      end
   end
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer #(
   parameter int TW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          pwm_mode,
   input  logic [TW-1:0] period,
   output logic [TW-1:0] tc,
   output logic          wrap
);
   assign wrap = tick && pwm_mode && (tc >= period);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tc <= '0;
      end else if (tick) begin
         if (wrap) tc <= '0;
         else      tc <= tc + 1'b1;
      end
   end
endmodule

// File: rtl/pwm_match_bank.sv
module pwm_match_bank #(
   parameter int TW     = 32,
   parameter int NMATCH = 7,
   parameter int AW     = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [AW-1:0]               wr_addr,
   input  logic [TW-1:0]               wr_data,
   input  logic                        pwm_mode,
   input  logic                        wrap,
   output logic [NMATCH-1:0][TW-1:0]   act,
   output logic [NMATCH-1:0]           pend
);
   import pwm_pkg::*;

   localparam logic [AW-1:0] REL_A = AW'(rel_addr(NMATCH));

   logic [NMATCH-1:0][TW-1:0] shd_q;
   logic                      rel_wr;

   assign rel_wr = wr_en && (wr_addr == REL_A);

   for (genvar k = 0; k < NMATCH; k++) begin : g_slot
      logic hit;
      assign hit = wr_en && (wr_addr == AW'(k));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            shd_q[k] <= '0;
            act[k]   <= '0;
            pend[k]  <= 1'b0;
         end else begin
            if (hit) shd_q[k] <= wr_data;

            if (wrap && pend[k])       act[k] <= shd_q[k];
            else if (!pwm_mode && hit) act[k] <= wr_data;

            pend[k] <= (pend[k] && !wrap) || (rel_wr && wr_data[k]);
         end
      end
   end
endmodule

// File: rtl/pwm_edge_unit.sv
module pwm_edge_unit #(
   parameter int TW     = 32,
   parameter bit DBL_EN = 1'b1
) (
   input  logic          ena,
   input  logic          dbl,
   input  logic [TW-1:0] tc,
   input  logic [TW-1:0] set_val,
   input  logic [TW-1:0] clr_val,
   output logic          out
);
   import pwm_pkg::*;

   if (DBL_EN) begin : g_dual
      edge_mode_e mode;
      assign mode = edge_mode_e'(dbl);
      always_comb begin
         if (!ena)                     out = 1'b0;
         else if (mode == EDGE_DOUBLE) out = (tc >= set_val) && (tc < clr_val);
         else                          out = (tc < clr_val);
      end
   end else begin : g_single
      logic unused_set;
      assign unused_set = ^{set_val, dbl};
      assign out = ena && (tc < clr_val);
   end
endmodule

// File: rtl/dual_edge_pwm.sv
module dual_edge_pwm #(
   parameter  int NCH    = 3,
   parameter  int TW     = 32,
   parameter  bit DBL_EN = 1'b1,
   localparam int NMATCH = 2*NCH + 1,
   localparam int AW     = $clog2(NMATCH + 3)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [TW-1:0]     wr_data,
   output logic [NCH-1:0]    pwm_out,
   output logic [TW-1:0]     tc_value,
   output logic [NMATCH-1:0] match_hit,
   output logic [NMATCH-1:0] latch_pend
);
   import pwm_pkg::*;

   localparam logic [AW-1:0] CTRL_A = AW'(ctrl_addr(NMATCH));
   localparam logic [AW-1:0] PSC_A  = AW'(psc_addr(NMATCH));

   initial begin
      assert (NCH >= 1) else $fatal(1, "NCH must be at least 1");
      assert (TW >= 2) else $fatal(1, "TW must be at least 2");
      assert (TW >= NMATCH) else $fatal(1, "release register needs NMATCH data bits");
      assert (TW >= CTRL_DBL_LSB + NCH) else $fatal(1, "control register too narrow");
   end

   logic                      run_q, pwm_q;
   logic [NCH-1:0]            dbl_q, dbl_eff;
   logic [TW-1:0]             psc_q;
   logic                      tick, wrap;
   logic [TW-1:0]             tc_q;
   logic [NMATCH-1:0][TW-1:0] act_q;
   logic [NMATCH-1:0]         latch_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         pwm_q <= 1'b0;
         dbl_q <= '0;
         psc_q <= '0;
      end else if (wr_en) begin
         if (wr_addr == CTRL_A) begin
            run_q <= wr_data[CTRL_RUN_BIT];
            pwm_q <= wr_data[CTRL_PWM_BIT];
            dbl_q <= wr_data[CTRL_DBL_LSB +: NCH];
         end
         if (wr_addr == PSC_A) psc_q <= wr_data;
      end
   end

   assign dbl_eff = DBL_EN ? dbl_q : '0;

   pwm_prescaler #(.TW(TW)) u_psc (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run_q),
      .limit (psc_q),
      .tick  (tick)
   );

   pwm_timer #(.TW(TW)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .pwm_mode (pwm_q),
      .period   (act_q[0]),
      .tc       (tc_q),
      .wrap     (wrap)
   );

   pwm_match_bank #(.TW(TW), .NMATCH(NMATCH), .AW(AW)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .pwm_mode (pwm_q),
      .wrap     (wrap),
      .act      (act_q),
      .pend     (latch_q)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_chan
      pwm_edge_unit #(.TW(TW), .DBL_EN(DBL_EN)) u_edge (
         .ena     (pwm_q),
         .dbl     (dbl_eff[c]),
         .tc      (tc_q),
         .set_val (act_q[2*c+1]),
         .clr_val (act_q[2*c+2]),
         .out     (pwm_out[c])
      );
   end

   for (genvar k = 0; k < NMATCH; k++) begin : g_hit
      assign match_hit[k] = run_q && (tc_q == act_q[k]);
   end

   assign tc_value   = tc_q;
   assign latch_pend = latch_q;
endmodule

// File: rtl/dual_edge_pwm_chk.sv
module dual_edge_pwm_chk #(
   parameter  int NCH    = 3,
   parameter  int TW     = 32,
   localparam int NMATCH = 2*NCH + 1,
   localparam int AW     = $clog2(NMATCH + 3)
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      wr_en,
   input logic [AW-1:0]             wr_addr,
   input logic                      run,
   input logic                      pwm_mode,
   input logic [NCH-1:0]            dbl,
   input logic                      wrap,
   input logic [TW-1:0]             tc,
   input logic [NMATCH-1:0][TW-1:0] act,
   input logic [NMATCH-1:0]         pend,
   input logic [NCH-1:0]            pwm_out
);
   localparam logic [AW-1:0] REL_A = AW'(NMATCH + 2);

   // R1
   a_r1_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> $stable(tc));

   // R2
   a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (tc == '0));

   // R3
   a_r3_active_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_mode && !wrap) |=> $stable(act));

   // R4
   a_r4_pend_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && !(wr_en && wr_addr == REL_A)) |=> (pend == '0));

   // R8
   a_r8_timer_outputs_low: assert property (@(posedge clk) disable iff (!rst_n)
      !pwm_mode |-> (pwm_out == '0));

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      // R7
      a_r7_equal_edges_low: assert property (@(posedge clk) disable iff (!rst_n)
         (pwm_mode && dbl[c] && act[2*c+1] == act[2*c+2]) |-> !pwm_out[c]);
      // R5
      a_r5_single_high_at_start: assert property (@(posedge clk) disable iff (!rst_n)
         (pwm_mode && !dbl[c] && tc == '0 && act[2*c+2] != '0) |-> pwm_out[c]);
   end
endmodule

bind dual_edge_pwm dual_edge_pwm_chk #(.NCH(NCH), .TW(TW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_addr  (wr_addr),
   .run      (run_q),
   .pwm_mode (pwm_q),
   .dbl      (dbl_eff),
   .wrap     (wrap),
   .tc       (tc_q),
   .act      (act_q),
   .pend     (latch_q),
   .pwm_out  (pwm_out)
);

// File: tb/dual_edge_pwm_tb.sv
module dual_edge_pwm_tb;
   localparam int NCH = 3;
   localparam int TW  = 32;
   localparam int NM  = 2*NCH + 1;
   localparam int AW  = $clog2(NM + 3);
   localparam int A_CTRL = NM, A_PSC = NM + 1, A_REL = NM + 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [TW-1:0] wr_data = '0;
   logic [NCH-1:0] pwm_out;
   logic [TW-1:0] tc_value;
   logic [NM-1:0] match_hit, latch_pend;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   typedef struct {
      int             tcv;
      logic [NCH-1:0] exp;
      string          tag;
   } item_t;
   item_t q[$];

   always #5 clk = ~clk;

   dual_edge_pwm #(.NCH(NCH), .TW(TW)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .pwm_out(pwm_out), .tc_value(tc_value), .match_hit(match_hit), .latch_pend(latch_pend)
   );

   task automatic check(input string tag, input logic [TW-1:0] act, input logic [TW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   // called at a negedge; returns at the negedge after the write is captured
   task automatic wr(input int a, input logic [TW-1:0] d);
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // expected output from the requirement text, channel 0 single, 1 and 2 double
   function automatic logic [NCH-1:0] expect_out(input int t, input int m2, input int m3,
                                                 input int m4, input int m5, input int m6);
      logic [NCH-1:0] e;
      e[0] = (t < m2);
      e[1] = (t >= m3) && (t < m4);
      e[2] = (t >= m5) && (t < m6);
      return e;
   endfunction

   task automatic push(input int from, input int to, input int m2, input int m3,
                       input int m4, input int m5, input int m6, input string tag);
      for (int t = from; t <= to; t++) begin
         item_t it;
         it.tcv = t;
         it.exp = expect_out(t, m2, m3, m4, m5, m6);
         it.tag = tag;
         q.push_back(it);
      end
   endtask

   task automatic wait_tc(input int v);
      do @(negedge clk); while (tc_value != TW'(v));
   endtask

   // monitor: samples 2 ns after each rising edge
   initial begin
      forever begin
         @(posedge clk); #2;
         if (q.size() != 0 && tc_value == TW'(q[0].tcv)) begin
            item_t it;
            it = q.pop_front();
            check($sformatf("%s pwm_out at tc=%0d", it.tag, it.tcv), TW'(pwm_out), TW'(it.exp));
         end
      end
   end

   initial begin
      #2_000_000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
      end
   end

   initial begin
      int cnt;
      logic [TW-1:0] snap;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 tc after reset", tc_value, 0);
      check("R9 pwm_out after reset", TW'(pwm_out), 0);
      check("R9 latch_pend after reset", TW'(latch_pend), 0);
      check("R9 match_hit after reset", TW'(match_hit), 0);

      // PWM mode, channels 1 and 2 double-edge, stopped
      wr(A_CTRL, 32'd26);
      wr(0, 19); wr(2, 5); wr(3, 4); wr(4, 10); wr(5, 10); wr(6, 16);
      check("R3 shadow writes leave pwm_out", TW'(pwm_out), 0);
      wr(A_CTRL, 32'd27);
      repeat (3) @(negedge clk);
      check("R3 unreleased period keeps tc at 0", tc_value, 0);
      check("R3 unreleased values keep pwm_out low", TW'(pwm_out), 0);

      wr(A_REL, 32'h7F);
      check("R4 release sets pending", TW'(latch_pend), 32'h7F);
      @(negedge clk);
      check("R4 pending clears after transfer", TW'(latch_pend), 0);
      check("R2 new period starts at 0", tc_value, 0);
      check("R5 single-edge high at period start", TW'(pwm_out), TW'(expect_out(0, 5, 4, 10, 10, 16)));
      push(1, 19, 5, 4, 10, 10, 16, "R5 R6 first period");
      push(0, 0, 5, 4, 10, 10, 16, "R2 wrap after match0");
      wait (q.size() == 0);

      // mid-period release: old values hold until the boundary
      wait_tc(3);
      wr(2, 12); wr(4, 14); wr(A_REL, 32'h14);
      check("R4 mid-period pending", TW'(latch_pend), 32'h14);
      push(7, 19, 5, 4, 10, 10, 16, "R3 old values rest of period");
      push(0, 19, 12, 4, 14, 10, 16, "R4 new values next period");
      wait (q.size() == 0);

      // equal set and clear on channel 1
      wait_tc(2);
      wr(3, 7); wr(4, 7); wr(A_REL, 32'h18);
      push(0, 19, 12, 7, 7, 10, 16, "R7 equal edges");
      wait (q.size() == 0);

      // prescaler
      @(negedge clk);
      wr(A_PSC, 2);
      snap = tc_value;
      do @(negedge clk); while (tc_value == snap);
      snap = tc_value; cnt = 0;
      do begin @(negedge clk); cnt++; end while (tc_value == snap);
      check("R1 cycles per step with prescale 2", TW'(cnt), 3);
      wr(A_CTRL, 32'd26);
      snap = tc_value;
      repeat (6) @(negedge clk);
      check("R1 counter holds when stopped", tc_value, snap);
      wr(A_PSC, 0);

      // timer mode
      wr(A_CTRL, 32'd25);
      check("R8 outputs low in timer mode", TW'(pwm_out), 0);
      cnt = 0;
      while (tc_value != 30 && cnt < 100) begin @(negedge clk); cnt++; end
      check("R8 counter passes match0 in timer mode", tc_value, 30);
      wr(1, 60);
      check("R8 no pending bit needed in timer mode", TW'(latch_pend[1]), 0);
      cnt = 0;
      while (!match_hit[1] && cnt < 100) begin @(negedge clk); cnt++; end
      check("R8 match_hit[1] at immediate value", tc_value, 60);
      check("R8 outputs still low", TW'(pwm_out), 0);

      done = 1'b1;
      summary();
   end
endmodule